// File: doc/BRIEF.md
# Two-Priority Ordered Message Channel

This block carries coherence messages between agents over one shared delivery path while keeping two traffic classes apart. Responses travel in the high-priority class and requests in the low-priority class. Each class has its own first-in first-out queue, and the consumer sees a single valid/ready output. A low-priority message is offered only while the high-priority queue holds nothing, so requests can never stand in front of responses.

The producer presents one message per cycle together with a class flag. It receives a separate ready signal for each class, which comes only from that class's own queue having room. A backlog of requests therefore never stops a response from entering. Order inside a class is strictly preserved, because a request that overtook a response could deadlock the coherence protocol. A message holds a request/response kind bit, an agent id, an address, a 2-bit state and a data word.

Top module: `prio_msg_channel`

## Requirements
- R1: After reset, and whenever both queues are empty, `out_valid` is 0. Directly after reset, `in_ready_hi` and `in_ready_lo` are both 1.
- R2: While the high-priority queue holds any message, the output offers a high-priority message (`out_hi` = 1). A low-priority message is offered only when the high-priority queue is empty. A low-priority message that is waiting on the output is replaced by a newly accepted high-priority message.
- R3: Within each class, messages leave in the order they were accepted.
- R4: `in_ready_hi` is 0 when the high-priority queue holds `DEPTH_HI` messages, and `in_ready_lo` is 0 when the low-priority queue holds `DEPTH_LO` messages.
- R5: `in_ready_hi` is 1 whenever the high-priority queue has room, whatever the fill level of the low-priority queue.
- R6: While `out_valid` = 1 and `out_ready` = 0 with a high-priority message offered, the offer stays the same on the next cycle. A low-priority offer stays the same unless a high-priority message replaces it.
- R7: A message accepted at a clock edge (`in_valid` = 1 and the ready of its class = 1) into an empty channel is offered on `out_valid` from that same edge, with one cycle of latency.
- R8: All fields (kind, id, address, state, data) arrive at the output unchanged. The class appears on `out_hi`, with 1 meaning high priority.
- R9: A message offered while the ready of its class is 0 is not stored and never appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input message valid |
| in_hi | input | 1 | Input class: 1 high priority (response), 0 low priority (request) |
| in_kind | input | 1 | Message kind: 1 response, 0 request |
| in_peer | input | ID_W | Source/destination agent id |
| in_addr | input | ADDR_W | Line address |
| in_state | input | 2 | Coherence state field |
| in_data | input | DATA_W | Data word |
| in_ready_hi | output | 1 | High-priority queue can accept |
| in_ready_lo | output | 1 | Low-priority queue can accept |
| out_valid | output | 1 | Output message valid |
| out_ready | input | 1 | Consumer takes the offered message |
| out_hi | output | 1 | Class of the offered message |
| out_kind | output | 1 | Offered message kind |
| out_peer | output | ID_W | Offered agent id |
| out_addr | output | ADDR_W | Offered address |
| out_state | output | 2 | Offered state field |
| out_data | output | DATA_W | Offered data word |

## Verification
An accepted message enters its queue at the accepting edge. It is offered on the output from that same edge, and from the next edge the class ready reflects the new fill. A handshake on the output removes the message at that edge, and the next message of the same class, or the next low-priority one, appears right after it. The bench drives inputs on falling edges, moves `out_ready` only on rising edges, and samples every output on falling edges. The scoreboard updates its expected queues at the same edges where the design's queues change, so each comparison falls half a cycle after the edge that produced the value.

// File: rtl/prio_chan_pkg.sv
package prio_chan_pkg;
  parameter int ID_W   = 3;
  parameter int ADDR_W = 12;
  parameter int DATA_W = 16;

  // kind: 1 = response, 0 = request
  typedef struct packed {
    logic              kind;
    logic [ID_W-1:0]   peer;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        state;
    logic [DATA_W-1:0] data;
  } msg_t;

  localparam int MSG_W = $bits(msg_t);
endpackage

// File: rtl/prio_msg_fifo.sv
module prio_msg_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             not_full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign not_empty = (cnt_q != '0);
  assign not_full  = (cnt_q != FULL);
  assign do_push   = push & not_full;
  assign do_pop    = pop & not_empty;
  assign head      = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/prio_out_sel.sv
module prio_out_sel #(
  parameter int WIDTH = 8
) (
  input  logic             hi_avail,
  input  logic [WIDTH-1:0] hi_head,
  input  logic             lo_avail,
  input  logic [WIDTH-1:0] lo_head,
  input  logic             take,
  output logic             offer,
  output logic             offer_hi,
  output logic [WIDTH-1:0] offer_msg,
  output logic             hi_pop,
  output logic             lo_pop
);
  always_comb begin
    offer     = hi_avail | lo_avail;
    offer_hi  = hi_avail;
    offer_msg = hi_avail ? hi_head : lo_head;
    hi_pop    = take & hi_avail;
    lo_pop    = take & ~hi_avail & lo_avail;
  end
endmodule

// File: rtl/prio_msg_channel.sv
module prio_msg_channel
  import prio_chan_pkg::*;
#(
  parameter int DEPTH_HI = 4,
  parameter int DEPTH_LO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_hi,
  input  logic              in_kind,
  input  logic [ID_W-1:0]   in_peer,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_state,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready_hi,
  output logic              in_ready_lo,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hi,
  output logic              out_kind,
  output logic [ID_W-1:0]   out_peer,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_state,
  output logic [DATA_W-1:0] out_data
);
  msg_t in_msg, hi_head, lo_head, sel_msg;
  logic hi_avail, lo_avail, hi_pop, lo_pop;

  always_comb begin
    in_msg.kind  = in_kind;
    in_msg.peer  = in_peer;
    in_msg.addr  = in_addr;
    in_msg.state = in_state;
    in_msg.data  = in_data;
  end

  prio_msg_fifo #(.DEPTH(DEPTH_HI), .WIDTH(MSG_W)) hi_q_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid & in_hi),
    .push_data (in_msg),
    .pop       (hi_pop),
    .head      (hi_head),
    .not_empty (hi_avail),
    .not_full  (in_ready_hi)
  );

  prio_msg_fifo #(.DEPTH(DEPTH_LO), .WIDTH(MSG_W)) lo_q_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid & ~in_hi),
    .push_data (in_msg),
    .pop       (lo_pop),
    .head      (lo_head),
    .not_empty (lo_avail),
    .not_full  (in_ready_lo)
  );

  prio_out_sel #(.WIDTH(MSG_W)) sel_i (
    .hi_avail  (hi_avail),
    .hi_head   (hi_head),
    .lo_avail  (lo_avail),
    .lo_head   (lo_head),
    .take      (out_ready),
    .offer     (out_valid),
    .offer_hi  (out_hi),
    .offer_msg (sel_msg),
    .hi_pop    (hi_pop),
    .lo_pop    (lo_pop)
  );

  assign out_kind  = sel_msg.kind;
  assign out_peer  = sel_msg.peer;
  assign out_addr  = sel_msg.addr;
  assign out_state = sel_msg.state;
  assign out_data  = sel_msg.data;
endmodule

// File: rtl/prio_msg_channel_chk.sv
module prio_msg_channel_chk
  import prio_chan_pkg::*;
#(
  parameter int DEPTH_HI = 4,
  parameter int DEPTH_LO = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_hi,
  input logic              in_ready_hi,
  input logic              in_ready_lo,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hi,
  input logic              out_kind,
  input logic [ID_W-1:0]   out_peer,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_state,
  input logic [DATA_W-1:0] out_data
);
  localparam int MAXD  = (DEPTH_HI > DEPTH_LO) ? DEPTH_HI : DEPTH_LO;
  localparam int OCC_W = $clog2(MAXD + 1) + 1;

  logic [OCC_W-1:0] hi_occ, lo_occ;
  logic hi_in, lo_in, hi_out, lo_out, acc;

  assign hi_in  = in_valid & in_hi & in_ready_hi;
  assign lo_in  = in_valid & ~in_hi & in_ready_lo;
  assign hi_out = out_valid & out_ready & out_hi;
  assign lo_out = out_valid & out_ready & ~out_hi;
  assign acc    = hi_in | lo_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_occ <= '0;
      lo_occ <= '0;
    end else begin
      hi_occ <= hi_occ + OCC_W'(hi_in) - OCC_W'(hi_out);
      lo_occ <= lo_occ + OCC_W'(lo_in) - OCC_W'(lo_out);
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_occ == '0 && lo_occ == '0) |-> !out_valid);

  // R2
  lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hi) |-> (hi_occ == '0));

  // R4
  hi_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_occ == OCC_W'(DEPTH_HI)) |-> !in_ready_hi);

  // R4
  lo_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_occ == OCC_W'(DEPTH_LO)) |-> !in_ready_lo);

  // R5
  hi_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_occ < OCC_W'(DEPTH_HI)) |-> in_ready_hi);

  // R6
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && out_hi) |=>
      (out_valid && out_hi &&
       $stable({out_kind, out_peer, out_addr, out_state, out_data})));

  // R6
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !out_hi) |=>
      (out_valid && (out_hi ||
       $stable({out_kind, out_peer, out_addr, out_state, out_data}))));

  // R7
  first_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_occ == '0 && lo_occ == '0 && acc) |=> out_valid);
endmodule

bind prio_msg_channel prio_msg_channel_chk #(
  .DEPTH_HI(DEPTH_HI),
  .DEPTH_LO(DEPTH_LO)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_hi       (in_hi),
  .in_ready_hi (in_ready_hi),
  .in_ready_lo (in_ready_lo),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_hi      (out_hi),
  .out_kind    (out_kind),
  .out_peer    (out_peer),
  .out_addr    (out_addr),
  .out_state   (out_state),
  .out_data    (out_data)
);

// File: tb/prio_msg_channel_tb_top.sv
module prio_msg_channel_tb_top;
  import prio_chan_pkg::*;

  localparam int DEPTH_HI = 4;
  localparam int DEPTH_LO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_hi = 1'b0, in_kind = 1'b0;
  logic [ID_W-1:0]   in_peer = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [1:0]        in_state = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready_hi, in_ready_lo, out_valid, out_hi, out_kind;
  logic out_ready = 1'b0;
  logic [ID_W-1:0]   out_peer;
  logic [ADDR_W-1:0] out_addr;
  logic [1:0]        out_state;
  logic [DATA_W-1:0] out_data;

  logic man_rdy = 1'b0;
  logic rnd_rdy = 1'b0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  msg_t exp_hi[$];
  msg_t exp_lo[$];

  always #10 clk = ~clk;

  prio_msg_channel #(.DEPTH_HI(DEPTH_HI), .DEPTH_LO(DEPTH_LO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_hi(in_hi), .in_kind(in_kind), .in_peer(in_peer),
    .in_addr(in_addr), .in_state(in_state), .in_data(in_data),
    .in_ready_hi(in_ready_hi), .in_ready_lo(in_ready_lo),
    .out_valid(out_valid), .out_ready(out_ready), .out_hi(out_hi),
    .out_kind(out_kind), .out_peer(out_peer), .out_addr(out_addr),
    .out_state(out_state), .out_data(out_data)
  );

  always @(posedge clk) out_ready <= rnd_rdy ? (($urandom % 3) != 0) : man_rdy;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic msg_t cur_out();
    msg_t m;
    m.kind = out_kind; m.peer = out_peer; m.addr = out_addr;
    m.state = out_state; m.data = out_data;
    return m;
  endfunction

  function automatic msg_t mk(input bit hi, input int n);
    msg_t m;
    m.kind  = hi;
    m.peer  = ID_W'(n * 3);
    m.addr  = ADDR_W'(n * 37 + 5);
    m.state = 2'(n);
    m.data  = DATA_W'(n * 911 + 1);
    return m;
  endfunction

  // Driver: holds the message until its class accepts it, then records it.
  task automatic send(input bit hi, input msg_t m);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1; in_hi = hi; in_kind = m.kind; in_peer = m.peer;
    in_addr = m.addr; in_state = m.state; in_data = m.data;
    forever begin
      acc = hi ? in_ready_hi : in_ready_lo;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    if (hi) exp_hi.push_back(m); else exp_lo.push_back(m);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: compares each delivered message with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      msg_t got, want;
      got = cur_out();
      if (out_hi) begin
        if (exp_hi.size() == 0) check(1'b0, "R9 unexpected high message", got, 0);
        else begin
          want = exp_hi.pop_front();
          check(got == want, "R3/R8 high order", got, want);
        end
      end else begin
        check(exp_hi.size() == 0, "R2 low offered with high pending", exp_hi.size(), 0);
        if (exp_lo.size() == 0) check(1'b0, "R9 unexpected low message", got, 0);
        else begin
          want = exp_lo.pop_front();
          check(got == want, "R3/R8 low order", got, want);
        end
      end
    end
  end

  task automatic drain();
    man_rdy = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (exp_hi.size() == 0 && exp_lo.size() == 0) break;
    end
    repeat (3) @(negedge clk);
    check(exp_hi.size() == 0 && exp_lo.size() == 0, "R3 all delivered",
          exp_hi.size() + exp_lo.size(), 0);
    check(!out_valid, "R1 idle after drain", out_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    msg_t hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(in_ready_hi && in_ready_lo, "R1 readies after reset", {in_ready_hi, in_ready_lo}, 3);

    // R7, R8: first message visible one cycle after acceptance
    send(1'b0, mk(1'b0, 1));
    @(negedge clk);
    check(out_valid && !out_hi, "R7 first offer", {out_valid, out_hi}, 2);
    check(cur_out() == mk(1'b0, 1), "R8 fields", cur_out(), mk(1'b0, 1));

    // R4, R5: fill the low queue
    for (int i = 2; i <= DEPTH_LO; i++) send(1'b0, mk(1'b0, i));
    @(negedge clk);
    check(!in_ready_lo, "R4 low full", in_ready_lo, 0);
    check(in_ready_hi, "R5 high ready with low full", in_ready_hi, 1);

    // R9: offer to a full low queue for two cycles, not recorded
    in_valid = 1'b1; in_hi = 1'b0; in_data = 16'hdead;
    @(posedge clk); @(negedge clk); @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check(!in_ready_lo, "R9 low still full", in_ready_lo, 0);

    // R2: high message replaces the waiting low offer
    send(1'b1, mk(1'b1, 50));
    @(negedge clk);
    check(out_valid && out_hi, "R2 high preempts", {out_valid, out_hi}, 3);
    check(cur_out() == mk(1'b1, 50), "R8 high fields", cur_out(), mk(1'b1, 50));

    // R6: held offer stays stable
    hold = cur_out();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid && out_hi && cur_out() == hold, "R6 hold", cur_out(), hold);
    end

    // R4: fill the high queue
    for (int i = 51; i < 50 + DEPTH_HI; i++) send(1'b1, mk(1'b1, i));
    @(negedge clk);
    check(!in_ready_hi, "R4 high full", in_ready_hi, 0);

    // R3, R9: drain in order, dropped message never appears
    drain();
    check(in_ready_hi && in_ready_lo, "R4 ready after drain", {in_ready_hi, in_ready_lo}, 3);

    // Mixed traffic under random consumer stalls
    man_rdy = 1'b0;
    rnd_rdy = 1'b1;
    for (int n = 0; n < 400; n++) begin
      bit hi;
      hi = (($urandom % 2) == 0);
      send(hi, mk(hi, 100 + n));
      if ((n % 7) == 0) @(negedge clk);
    end
    rnd_rdy = 1'b0;
    repeat (2) @(posedge clk);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule